// File: doc/BRIEF.md
# Correction Count Estimator for Residue Reduction

This block estimates the integer overflow count that appears when a value held as a set of residues is rebuilt through the Chinese remainder theorem. The count is the floor of the sum of gamma_i / m_i over all channels. Here gamma_i is a per-channel weighted residue and m_i is the channel modulus. The block replaces every modulus with the power of two 2^W. It keeps only the Q most significant bits of each gamma_i. It adds a constant fraction Delta so that the floor lands on the exact count and not on one below it. Every division is a bit selection, and the circuit contains no divider.

The N truncated values and one constant row that holds Delta form N+1 rows. A recursive carry-save tree of 3:2 compressors reduces these rows to two. One carry-propagate adder then adds the two rows. The integer part above the binary point is the output. Delta is a Q-bit fraction (DELTA_FRAC / 2^Q), appended below the integer sum. The count is meant as the address into an N-entry table of correction residues, which sits outside this block.

The result is exact when three conditions hold:
- every modulus lies in the interval [(2N-1)/(2N)*2^W, 2^W];
- Delta is larger than the combined error from the denominator and truncation approximations, and smaller than 1;
- the represented value X is less than (1-Delta) times the dynamic range.

Under these conditions the count is always below N.

Top module: `correction_estimator`

## Requirements
- R1: While rst is high, and on the first cycle after it is sampled high, valid_o is 0 and alpha_o is 0.
- R2: Each vector accepted with valid_i high produces exactly one valid_o pulse. The pulse comes LAT = 2 + TREE_REG clock edges after the accepting edge, and valid_o is never high otherwise.
- R3: For any input vector, alpha_o is the low AW bits of floor((S + DELTA_FRAC) / 2^Q), where AW = ceil(log2 N_CH). S is the sum of gamma_i[W-1 -: Q] over all channels, and channel i sits at gamma_i[i*W +: W].
- R4: The W-Q least significant bits of every channel have no effect on alpha_o.
- R5: Take moduli in the interval [(2N-1)/(2N)*2^W, 2^W], with the combined approximation error below Delta, and take gamma_i = <x_i * (D/m_i)^-1> mod m_i for a value X < (1-Delta)*D. Then alpha_o equals the exact count (sum of gamma_i*D/m_i - X)/D, and that count is below N.
- R6: Vectors presented on consecutive cycles produce results on consecutive cycles, in order.
- R7: While valid_o is low, alpha_o keeps its previous value, whatever gamma_i does.
- R8: The offset decides the rounding edge. An all-zero vector gives floor(DELTA_FRAC/2^Q). A truncated sum of 2^Q - DELTA_FRAC gives 1 when DELTA_FRAC < 2^Q, and a sum one lower gives 0.
- R9: A reset asserted while vectors are in flight discards them, and no valid_o follows for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | gamma_i holds a vector to evaluate |
| gamma_i | input | N_CH*GAMMA_W | Per-channel weighted residues, channel i at bits [i*GAMMA_W +: GAMMA_W] |
| valid_o | output | 1 | alpha_o holds a new count |
| alpha_o | output | AW | Estimated correction count |

## Verification
An upset anywhere in the compressor tree or in the offset row changes the value of the final sum. It therefore shows up as a wrong alpha_o on the very valid_o pulse that carries that vector, LAT cycles after it was accepted. Dropped or stuck valid bits show up as a missing or extra pulse at the wrong cycle. Register data that is not held while idle shows up as an alpha_o that changes while valid_o is low. A too-small offset reads correctly on most vectors. It shows up only on legal vectors whose fraction sum is near an integer boundary, so those vectors are swept over the allowed value range.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  // width of the integer+fraction sum of N truncated rows plus the offset row
  function automatic int unsigned cfe_sum_w(input int unsigned n_ch, input int unsigned q);
    return q + $clog2(n_ch + 1);
  endfunction

  // width of the correction count (ceil(log2 N), at least one bit)
  function automatic int unsigned cfe_alpha_w(input int unsigned n_ch);
    return (n_ch < 2) ? 1 : $clog2(n_ch);
  endfunction

  // rows left after one layer of 3:2 compressors
  function automatic int unsigned cfe_next_rows(input int unsigned rows);
    return 2 * (rows / 3) + (rows % 3);
  endfunction

  // number of compressor layers from a given row count down to two
  function automatic int unsigned cfe_layers(input int unsigned rows);
    int unsigned r;
    int unsigned n;
    r = rows;
    n = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/cfe_gamma_trim.sv
module cfe_gamma_trim #(
  parameter int unsigned N_CH    = 40,
  parameter int unsigned GAMMA_W = 14,
  parameter int unsigned Q       = 8
) (
  input  logic [N_CH*GAMMA_W-1:0] gamma_i,
  output logic [N_CH*Q-1:0]       top_o
);
  localparam int unsigned DROP = GAMMA_W - Q;

  if (Q >= GAMMA_W) begin : g_bad_q
    initial $error("Q must be smaller than GAMMA_W");
  end

  // keep the Q most significant bits of every channel; this is the divide by 2^DROP
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign top_o[c*Q +: Q] = gamma_i[c*GAMMA_W + DROP +: Q];
  end
endmodule

// File: rtl/cfe_csa_level.sv
module cfe_csa_level #(
  parameter int unsigned ROWS = 41,
  parameter int unsigned SW   = 14
) (
  input  logic [ROWS*SW-1:0] rows_i,
  output logic [SW-1:0]      sum_o,
  output logic [SW-1:0]      carry_o
);
  import cfe_pkg::*;

  localparam int unsigned TRIPLES = ROWS / 3;
  localparam int unsigned REST    = ROWS % 3;
  localparam int unsigned NEXT    = cfe_next_rows(ROWS);

  if (ROWS == 1) begin : g_one
    assign sum_o   = rows_i[SW-1:0];
    assign carry_o = '0;
  end else if (ROWS == 2) begin : g_two
    assign sum_o   = rows_i[SW-1:0];
    assign carry_o = rows_i[2*SW-1:SW];
  end else begin : g_reduce
    logic [NEXT*SW-1:0] nxt;

    for (genvar t = 0; t < TRIPLES; t++) begin : g_fa
      logic [SW-1:0] a, b, c, maj;
      assign a   = rows_i[(3*t)*SW   +: SW];
      assign b   = rows_i[(3*t+1)*SW +: SW];
      assign c   = rows_i[(3*t+2)*SW +: SW];
      assign maj = (a & b) | (a & c) | (b & c);
      assign nxt[(2*t)*SW   +: SW] = a ^ b ^ c;
      // the total fits in SW bits, so the carry dropped at the top is always zero
      assign nxt[(2*t+1)*SW +: SW] = {maj[SW-2:0], 1'b0};
    end

    for (genvar r = 0; r < REST; r++) begin : g_pass
      assign nxt[(2*TRIPLES+r)*SW +: SW] = rows_i[(3*TRIPLES+r)*SW +: SW];
    end

    cfe_csa_level #(
      .ROWS(NEXT),
      .SW  (SW)
    ) u_next (
      .rows_i (nxt),
      .sum_o  (sum_o),
      .carry_o(carry_o)
    );
  end
endmodule

// File: rtl/cfe_floor_add.sv
module cfe_floor_add #(
  parameter int unsigned SW = 14,
  parameter int unsigned Q  = 8,
  parameter int unsigned AW = 6
) (
  input  logic [SW-1:0] sum_i,
  input  logic [SW-1:0] carry_i,
  output logic [AW-1:0] alpha_o
);
  logic [SW-1:0] total;
  logic [SW+AW-1:0] padded;

  // final carry-propagate add; the floor is the slice above the binary point
  assign total   = sum_i + carry_i;
  assign padded  = {{AW{1'b0}}, total};
  assign alpha_o = padded[Q +: AW];
endmodule

// File: rtl/correction_estimator.sv
module correction_estimator #(
  parameter int unsigned N_CH       = 40,
  parameter int unsigned GAMMA_W    = 14,
  parameter int unsigned Q          = 8,
  parameter int unsigned DELTA_FRAC = 192,
  parameter bit          TREE_REG   = 1'b1,
  localparam int unsigned AW        = cfe_pkg::cfe_alpha_w(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic [N_CH*GAMMA_W-1:0] gamma_i,
  output logic                    valid_o,
  output logic [AW-1:0]           alpha_o
);
  import cfe_pkg::*;

  localparam int unsigned SW     = cfe_sum_w(N_CH, Q);
  localparam int unsigned ROWS   = N_CH + 1;
  localparam int unsigned LAYERS = cfe_layers(ROWS);

  if (DELTA_FRAC >= (1 << Q)) begin : g_bad_delta
    initial $error("DELTA_FRAC must be a proper Q-bit fraction");
  end
  if (LAYERS > 64) begin : g_bad_tree
    initial $error("compressor tree too deep");
  end

  // ---------------- stage 1: truncate and register ----------------
  logic [N_CH*Q-1:0] top_w;
  logic [N_CH*Q-1:0] top_q;
  logic              v1_q;

  cfe_gamma_trim #(
    .N_CH   (N_CH),
    .GAMMA_W(GAMMA_W),
    .Q      (Q)
  ) u_trim (
    .gamma_i(gamma_i),
    .top_o  (top_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      top_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) top_q <= top_w;
    end
  end

  // ---------------- rows: N truncated values plus the offset ----------------
  logic [ROWS*SW-1:0] rows_w;

  for (genvar c = 0; c < N_CH; c++) begin : g_row
    assign rows_w[c*SW +: SW] = {{(SW-Q){1'b0}}, top_q[c*Q +: Q]};
  end
  assign rows_w[N_CH*SW +: SW] = SW'(DELTA_FRAC);

  // ---------------- carry-save tree ----------------
  logic [SW-1:0] tree_sum_w, tree_carry_w;

  cfe_csa_level #(
    .ROWS(ROWS),
    .SW  (SW)
  ) u_tree (
    .rows_i (rows_w),
    .sum_o  (tree_sum_w),
    .carry_o(tree_carry_w)
  );

  // ---------------- optional register after the tree ----------------
  logic [SW-1:0] st_sum, st_carry;
  logic          st_v;

  if (TREE_REG) begin : g_tree_reg
    logic [SW-1:0] sum_q, carry_q;
    logic          v2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v2_q    <= 1'b0;
        sum_q   <= '0;
        carry_q <= '0;
      end else begin
        v2_q <= v1_q;
        if (v1_q) begin
          sum_q   <= tree_sum_w;
          carry_q <= tree_carry_w;
        end
      end
    end
    assign st_sum   = sum_q;
    assign st_carry = carry_q;
    assign st_v     = v2_q;
  end else begin : g_tree_comb
    assign st_sum   = tree_sum_w;
    assign st_carry = tree_carry_w;
    assign st_v     = v1_q;
  end

  // ---------------- final add, floor and output register ----------------
  logic [AW-1:0] alpha_w;

  cfe_floor_add #(
    .SW(SW),
    .Q (Q),
    .AW(AW)
  ) u_floor (
    .sum_i  (st_sum),
    .carry_i(st_carry),
    .alpha_o(alpha_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      alpha_o <= '0;
    end else begin
      valid_o <= st_v;
      if (st_v) alpha_o <= alpha_w;
    end
  end
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
  parameter int unsigned N_CH       = 40,
  parameter int unsigned GAMMA_W    = 14,
  parameter int unsigned Q          = 8,
  parameter int unsigned DELTA_FRAC = 192,
  parameter bit          TREE_REG   = 1'b1,
  localparam int unsigned AW        = cfe_pkg::cfe_alpha_w(N_CH)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    valid_i,
  input logic [N_CH*GAMMA_W-1:0] gamma_i,
  input logic                    valid_o,
  input logic [AW-1:0]           alpha_o
);
  localparam int unsigned LAT = 2 + (TREE_REG ? 1 : 0);
  localparam int unsigned RW  = Q + $clog2(N_CH + 1) + AW;

  logic [RW-1:0] ref_total;
  logic [AW-1:0] ref_alpha;

  always_comb begin
    ref_total = RW'(DELTA_FRAC);
    for (int c = 0; c < N_CH; c++)
      ref_total = ref_total + RW'(gamma_i[c*GAMMA_W + GAMMA_W - 1 -: Q]);
  end
  assign ref_alpha = ref_total[Q +: AW];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && alpha_o == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |-> ##LAT valid_o);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(valid_i, LAT));

  p_formula_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> alpha_o == $past(ref_alpha, LAT));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(alpha_o));
endmodule

bind correction_estimator cfe_checker #(
  .N_CH      (N_CH),
  .GAMMA_W   (GAMMA_W),
  .Q         (Q),
  .DELTA_FRAC(DELTA_FRAC),
  .TREE_REG  (TREE_REG)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .valid_i(valid_i),
  .gamma_i(gamma_i),
  .valid_o(valid_o),
  .alpha_o(alpha_o)
);

// File: tb/correction_estimator_tb_top.sv
module correction_estimator_tb_top;
  localparam int N   = 4;
  localparam int W   = 6;
  localparam int Q   = 4;
  localparam int DF  = 12;      // Delta = 0.75
  localparam int LAT = 3;
  localparam int AW  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           valid_i = 1'b0;
  logic [N*W-1:0] gamma_i = '0;
  logic           valid_o;
  logic [AW-1:0]  alpha_o;

  always #10 clk = ~clk;   // 50 MHz

  correction_estimator #(
    .N_CH(N), .GAMMA_W(W), .Q(Q), .DELTA_FRAC(DF), .TREE_REG(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .gamma_i(gamma_i),
    .valid_o(valid_o), .alpha_o(alpha_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int spur   = 0;
  int     exp_q[$];
  int     cyc_q[$];
  string  tag_q[$];
  longint mods[N] = '{59, 61, 62, 63};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int formula(input logic [N*W-1:0] g);
    int s;
    s = DF;
    for (int c = 0; c < N; c++) s += int'(g[c*W + W - 1 -: Q]);
    return (s >> Q) & ((1 << AW) - 1);
  endfunction

  task automatic push(input logic [N*W-1:0] g, input int exp, input string tag);
    @(negedge clk);
    valid_i = 1'b1;
    gamma_i = g;
    exp_q.push_back(exp);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      gamma_i = N*W'($urandom);
    end
  endtask

  // output monitor: value (R3/R4/R5/R8) and exact latency (R2, R6)
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        spur++;
        check(1'b0, "R2 unexpected valid_o", 1, 0);
      end else begin
        int e, c0;
        string t;
        e  = exp_q.pop_front();
        c0 = cyc_q.pop_front();
        t  = tag_q.pop_front();
        check(int'(alpha_o) == e, t, alpha_o, e);
        check(cyc == c0 + LAT, "R2 latency", cyc - c0, LAT);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [N*W-1:0] g;
    longint D, Di[N], inv[N];
    int hold;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid_o in reset", valid_o, 0);
    check(alpha_o == '0, "R1 alpha_o in reset", alpha_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid_o after reset", valid_o, 0);

    // R8: rounding edge set by the offset (2^Q - DF = 4)
    push('0, 0, "R8 zero vector");
    g = '0; g[W-1 -: Q] = 4'd4;
    push(g, 1, "R8 sum at edge");
    g = '0; g[W-1 -: Q] = 4'd3;
    push(g, 0, "R8 sum below edge");
    idle(LAT + 2);

    // R3 and R6: exhaustive over all truncated patterns, back to back
    for (int idx = 0; idx < (1 << (N*Q)); idx++) begin
      for (int c = 0; c < N; c++) begin
        g[c*W + W - 1 -: Q] = Q'(idx >> (c*Q));
        g[c*W +: W-Q]       = (W-Q)'($urandom);
      end
      push(g, formula(g), "R3 R6 truncated sum");
    end
    idle(LAT + 2);

    // R4: low bits changed, result identical to the low-bits-zero vector
    for (int k = 0; k < 64; k++) begin
      logic [N*W-1:0] base;
      base = N*W'($urandom);
      for (int c = 0; c < N; c++) base[c*W +: W-Q] = '0;
      g = base;
      for (int c = 0; c < N; c++) g[c*W +: W-Q] = (W-Q)'($urandom | 1);
      push(base, formula(base), "R4 low bits zero");
      push(g, formula(base), "R4 low bits ignored");
    end
    idle(LAT + 2);

    // R5: legal vectors from values X < (1-Delta)*D, exact count by CRT
    D = 1;
    for (int c = 0; c < N; c++) D *= mods[c];
    for (int c = 0; c < N; c++) begin
      Di[c] = D / mods[c];
      inv[c] = 0;
      for (longint t = 1; t < mods[c]; t++)
        if (((Di[c] % mods[c]) * t) % mods[c] == 1) inv[c] = t;
    end
    for (longint x = 0; x < (D + 3) / 4; x += 1171) begin
      for (int pass = 0; pass < 2; pass++) begin
        longint xv, acc;
        xv  = (pass == 0) ? x : ((D + 3) / 4 - 1 - x);
        acc = 0;
        for (int c = 0; c < N; c++) begin
          longint gm;
          gm = ((xv % mods[c]) * inv[c]) % mods[c];
          g[c*W +: W] = W'(gm);
          acc += gm * Di[c];
        end
        check((acc - xv) / D < N, "R5 count below N", (acc - xv) / D, N - 1);
        push(g, int'((acc - xv) / D), "R5 exact count");
      end
    end
    idle(LAT + 2);

    // R7: output holds while idle
    hold = alpha_o;
    for (int k = 0; k < 6; k++) begin
      idle(1);
      check(valid_o == 1'b0, "R7 valid_o idle", valid_o, 0);
      check(int'(alpha_o) == hold, "R7 alpha_o held", alpha_o, hold);
    end

    // R9: reset discards in-flight vectors
    g = '1;
    push(g, formula(g), "R9");
    push(g, formula(g), "R9");
    @(negedge clk);
    valid_i = 1'b0;
    rst = 1'b1;
    exp_q.delete(); cyc_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    spur = 0;
    idle(LAT + 4);
    check(spur == 0, "R9 no result after reset", spur, 0);
    check(alpha_o == '0, "R9 alpha_o cleared", alpha_o, 0);

    summary();
  end
endmodule